// File: doc/BRIEF.md
# Bit-Serial Multiply/Divide Unit

This unit forms an unsigned product or an unsigned quotient one bit at a time. A pulse on the multiply start input takes an 8-bit multiplicand and an 8-bit multiplier. A pulse on the divide start input takes a 16-bit dividend and an 8-bit divisor. After the start, each one-cycle strobe on the step input performs one iteration. A multiply needs eight iterations and a divide needs sixteen.

Both operations share two visible 16-bit result registers. The accumulator holds the product during a multiply and the remainder during a divide. The second register holds the multiplier during a multiply and the quotient during a divide; the multiplier shifts right on each iteration and the quotient shifts left. A third, hidden shift register carries the multiplicand or divisor. The partial contents of both visible registers can be read at the ports at any time, so a consumer that reads too early sees a partly formed result. A new start discards any operation in progress and begins again.

Top module: `bitser_mdu`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `res_acc` and `res_q` read 0 and `busy` is 0.
- R2: A multiply start loads `res_acc` = 0 and `res_q` = `b_in`. The multiplicand is `a_in[7:0]`. After exactly eight step strobes, `res_acc` = `a_in[7:0]` × `b_in` and `res_q` = 0.
- R3: A divide start loads `res_acc` = `a_in` and `res_q` = 0. After exactly sixteen step strobes with a nonzero `b_in`, `res_q` = `a_in` / `b_in` and `res_acc` = `a_in` mod `b_in`.
- R4: A divide by zero runs all sixteen steps normally. It ends with `res_q` = 16'hFFFF and `res_acc` equal to the dividend.
- R5: When neither a step strobe nor a start is present, `res_acc` and `res_q` hold their values.
- R6: After k of the eight multiply steps, `res_acc` = a × (b mod 2^k) and `res_q` = b >> k.
- R7: After k of the sixteen divide steps with divisor d, let D = d << (16−k). Then `res_q` = floor(a / D) and `res_acc` = a − `res_q`·D. When d = 0, `res_q` = 2^k − 1 and `res_acc` = a.
- R8: `busy` stays 1 until the last step of an operation and is 0 after it. Step strobes while `busy` is 0 change nothing.
- R9: A start during an operation abandons that operation. The new operation then produces its own correct result after its full number of steps.
- R10: When both starts are asserted in the same cycle, the divide is taken.
- R11: A step strobe in the same cycle as a start is ignored. The operation still needs its full number of later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | One-cycle iteration strobe |
| mul_start | input | 1 | Start a multiply |
| div_start | input | 1 | Start a divide (takes priority) |
| a_in | input | 16 | Dividend; low 8 bits are the multiplicand |
| b_in | input | 8 | Multiplier or divisor |
| res_acc | output | 16 | Product / remainder register |
| res_q | output | 16 | Multiplier / quotient register |
| busy | output | 1 | An operation has steps left |

## Verification
Every intermediate register value can be read, so a wrong iteration count shows up at once. So does a missed conditional add or a bad compare. The error appears at the ports on the next step edge, and the partial-result checks catch it well before the final value. A counter that stops early or runs late shows as a mistimed fall of `busy`, or as a result that keeps changing after it should have frozen. A lost abort shows as a corrupted result for the next operation.

// File: rtl/mdu_pkg.sv
// Package: shared constants and the operation encoding for the bit-serial
// multiply/divide unit. Assumes operand widths are set on the top module.
package mdu_pkg;
    localparam int unsigned DEF_OPW = 8;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MUL  = 2'd1,
        OP_DIV  = 2'd2
    } mdu_op_e;
endpackage

// File: rtl/mdu_seq.sv
// Sequencer: owns the two iteration down-counters. It turns the start
// pulses and step strobes into load and iterate enables for the datapath.
// Assumes: starts win over step, divide start wins over multiply start, and
// a start clears the counter of the other operation (abort).
module mdu_seq #(
    parameter int unsigned OPW = mdu_pkg::DEF_OPW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic mul_start,
    input  logic div_start,
    output logic load_mul,
    output logic load_div,
    output logic mul_go,
    output logic div_go,
    output logic busy
);
    import mdu_pkg::*;

    localparam int unsigned NW = 2 * OPW;
    localparam int unsigned CW = $clog2(NW + 1);

    logic [CW-1:0] mul_cnt;
    logic [CW-1:0] div_cnt;
    mdu_op_e       cur_op;
    logic          any_start;

    // Decode the start pulses with divide priority.
    always_comb begin
        any_start = mul_start | div_start;
        load_div  = div_start;
        load_mul  = mul_start & ~div_start;
        cur_op    = OP_IDLE;
        if (mul_cnt != '0) cur_op = OP_MUL;
        if (div_cnt != '0) cur_op = OP_DIV;
        mul_go    = step & ~any_start & (cur_op == OP_MUL);
        div_go    = step & ~any_start & (cur_op == OP_DIV);
        busy      = (cur_op != OP_IDLE);
    end

    // Load or count down the iteration counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_cnt <= '0;
            div_cnt <= '0;
        end else if (load_div) begin
            div_cnt <= CW'(NW);
            mul_cnt <= '0;
        end else if (load_mul) begin
            mul_cnt <= CW'(OPW);
            div_cnt <= '0;
        end else begin
            if (mul_go) mul_cnt <= mul_cnt - 1'b1;
            if (div_go) div_cnt <= div_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mdu_mul_step.sv
// One multiply iteration (combinational): a conditional add of the shifted
// multiplicand, then a right shift of the multiplier and a left shift of
// the multiplicand. Assumes the product never exceeds NW bits.
module mdu_mul_step #(
    parameter int unsigned OPW = mdu_pkg::DEF_OPW
) (
    input  logic [2*OPW-1:0] acc,
    input  logic [2*OPW-1:0] qm,
    input  logic [3*OPW-1:0] shf,
    output logic [2*OPW-1:0] acc_n,
    output logic [2*OPW-1:0] qm_n,
    output logic [3*OPW-1:0] shf_n
);
    localparam int unsigned NW = 2 * OPW;

    // Add when the low multiplier bit is set, then shift both operands.
    always_comb begin
        acc_n = qm[0] ? (acc + shf[NW-1:0]) : acc;
        qm_n  = qm >> 1;
        shf_n = shf << 1;
    end
endmodule

// File: rtl/mdu_div_step.sv
// One restoring-divide iteration (combinational): shift the quotient left
// and the divisor right, then subtract when the remainder covers the
// divisor and record a quotient one. Assumes the divisor starts at bit NW.
module mdu_div_step #(
    parameter int unsigned OPW = mdu_pkg::DEF_OPW
) (
    input  logic [2*OPW-1:0] acc,
    input  logic [2*OPW-1:0] qm,
    input  logic [3*OPW-1:0] shf,
    output logic [2*OPW-1:0] acc_n,
    output logic [2*OPW-1:0] qm_n,
    output logic [3*OPW-1:0] shf_n
);
    localparam int unsigned NW = 2 * OPW;

    logic [3*OPW-1:0] dsr;
    logic             fits;

    // Compare the remainder with the freshly shifted divisor and restore.
    always_comb begin
        dsr   = shf >> 1;
        fits  = ({{OPW{1'b0}}, acc} >= dsr);
        shf_n = dsr;
        qm_n  = {qm[NW-2:0], fits};
        acc_n = fits ? (acc - dsr[NW-1:0]) : acc;
    end
endmodule

// File: rtl/bitser_mdu.sv
// Top: bit-serial unsigned multiply (OPW x OPW) and divide (2*OPW / OPW)
// that share the result registers. It holds the registers, the operand
// loading and the selection of one step unit per iteration.
// Assumes step is a single-cycle strobe and that starts are pulses.
module bitser_mdu #(
    parameter int unsigned OPW = mdu_pkg::DEF_OPW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               mul_start,
    input  logic               div_start,
    input  logic [2*OPW-1:0]   a_in,
    input  logic [OPW-1:0]     b_in,
    output logic [2*OPW-1:0]   res_acc,
    output logic [2*OPW-1:0]   res_q,
    output logic               busy
);
    localparam int unsigned NW = 2 * OPW;
    localparam int unsigned SW = 3 * OPW;

    logic [NW-1:0] acc_r, qm_r;
    logic [SW-1:0] shf_r;
    logic [NW-1:0] m_acc, m_qm, d_acc, d_qm;
    logic [SW-1:0] m_shf, d_shf;
    logic          load_mul, load_div, mul_go, div_go;

    mdu_seq #(.OPW(OPW)) u_seq (
        .clk(clk), .rst_n(rst_n), .step(step),
        .mul_start(mul_start), .div_start(div_start),
        .load_mul(load_mul), .load_div(load_div),
        .mul_go(mul_go), .div_go(div_go), .busy(busy)
    );

    mdu_mul_step #(.OPW(OPW)) u_mul (
        .acc(acc_r), .qm(qm_r), .shf(shf_r),
        .acc_n(m_acc), .qm_n(m_qm), .shf_n(m_shf)
    );

    mdu_div_step #(.OPW(OPW)) u_div (
        .acc(acc_r), .qm(qm_r), .shf(shf_r),
        .acc_n(d_acc), .qm_n(d_qm), .shf_n(d_shf)
    );

    // Shared result and shift registers: load on start, else iterate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
            qm_r  <= '0;
            shf_r <= '0;
        end else if (load_div) begin
            acc_r <= a_in;
            qm_r  <= '0;
            shf_r <= {b_in, {NW{1'b0}}};
        end else if (load_mul) begin
            acc_r <= '0;
            qm_r  <= {{OPW{1'b0}}, b_in};
            shf_r <= {{NW{1'b0}}, a_in[OPW-1:0]};
        end else if (mul_go) begin
            acc_r <= m_acc;
            qm_r  <= m_qm;
            shf_r <= m_shf;
        end else if (div_go) begin
            acc_r <= d_acc;
            qm_r  <= d_qm;
            shf_r <= d_shf;
        end
    end

    // Expose the shared registers directly.
    always_comb begin
        res_acc = acc_r;
        res_q   = qm_r;
    end
endmodule

// File: rtl/bitser_mdu_chk.sv
// Checker: port-level properties of the multiply/divide unit, attached to
// every instance of the top module by the bind statement below.
module bitser_mdu_chk #(
    parameter int unsigned OPW = mdu_pkg::DEF_OPW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step,
    input logic             mul_start,
    input logic             div_start,
    input logic [2*OPW-1:0] a_in,
    input logic [OPW-1:0]   b_in,
    input logic [2*OPW-1:0] res_acc,
    input logic [2*OPW-1:0] res_q,
    input logic             busy
);
    // R5: no step and no start leaves both result registers unchanged.
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !mul_start && !div_start) |=> ($stable(res_acc) && $stable(res_q)));

    // R8: a step strobe while idle changes nothing.
    a_r8_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mul_start && !div_start) |=> ($stable(res_acc) && $stable(res_q) && !busy));

    // R2: a multiply load clears the product and exposes the multiplier.
    a_r2_mul_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_start && !div_start) |=> (res_acc == '0 && res_q == {{OPW{1'b0}}, $past(b_in)} && busy));

    // R3 and R10: a divide load (even with a multiply start) takes the dividend.
    a_r10_div_load: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |=> (res_acc == $past(a_in) && res_q == '0 && busy));

    // R1: an active reset clears the outputs by the next edge.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (res_acc == '0 && res_q == '0 && !busy));
endmodule

bind bitser_mdu bitser_mdu_chk #(.OPW(OPW)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step),
    .mul_start(mul_start), .div_start(div_start),
    .a_in(a_in), .b_in(b_in),
    .res_acc(res_acc), .res_q(res_q), .busy(busy)
);

// File: tb/sim_bitser_mdu.sv
// Bench: sweeps multiply and divide over wide operand sets and checks
// partial results, timing of busy, abort, priority and step/start overlap.
module sim_bitser_mdu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        mul_start = 1'b0;
    logic        div_start = 1'b0;
    logic [15:0] a_in = '0;
    logic [7:0]  b_in = '0;
    logic [15:0] res_acc, res_q;
    logic        busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bitser_mdu #(.OPW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .step(step),
        .mul_start(mul_start), .div_start(div_start),
        .a_in(a_in), .b_in(b_in),
        .res_acc(res_acc), .res_q(res_q), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] ea, input logic [15:0] eq);
        checks++;
        if (res_acc !== ea || res_q !== eq) begin
            failures++;
            $display("FAIL %s acc=%h q=%h expected acc=%h q=%h", tag, res_acc, res_q, ea, eq);
        end
    endtask

    task automatic chk_busy(input string tag, input logic eb);
        checks++;
        if (busy !== eb) begin
            failures++;
            $display("FAIL %s busy=%b expected busy=%b", tag, busy, eb);
        end
    endtask

    task automatic start_mul(input logic [15:0] a, input logic [7:0] b);
        @(negedge clk); a_in = a; b_in = b; mul_start = 1'b1; div_start = 1'b0; step = 1'b0;
    endtask

    task automatic start_div(input logic [15:0] a, input logic [7:0] b);
        @(negedge clk); a_in = a; b_in = b; div_start = 1'b1; mul_start = 1'b0; step = 1'b0;
    endtask

    task automatic do_steps(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); mul_start = 1'b0; div_start = 1'b0; step = 1'b1;
        end
        @(negedge clk); mul_start = 1'b0; div_start = 1'b0; step = 1'b0;
    endtask

    function automatic logic [7:0] mul_pick(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h55;
            4: return 8'h80; 5: return 8'hAA; 6: return 8'hFE; default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [15:0] div_pick(input int i);
        case (i)
            0: return 16'h0000; 1: return 16'h0001; 2: return 16'h00FF; 3: return 16'h1234;
            4: return 16'h8000; 5: return 16'hABCD; 6: return 16'hFFFE; default: return 16'hFFFF;
        endcase
    endfunction

    // Expected partial divide after k steps.
    task automatic div_expect(input int a, input int d, input int k,
                              output logic [15:0] ea, output logic [15:0] eq);
        int dd, q;
        if (d == 0) begin
            eq = 16'((1 << k) - 1); ea = 16'(a);
        end else begin
            dd = d << (16 - k);
            q = a / dd;
            eq = 16'(q); ea = 16'(a - q * dd);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] ea, eq;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 16'h0, 16'h0);
        chk_busy("R1 in reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 16'h0, 16'h0);
        chk_busy("R1 after release", 1'b0);

        // R2 sweep: every multiplicand against a set of multipliers.
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 8; bi++) begin
                start_mul(16'(a), mul_pick(bi));
                do_steps(8);
                chk("R2 product", 16'(a * int'(mul_pick(bi))), 16'h0);
            end
        end

        // R3/R4 sweep: every divisor against a set of dividends.
        for (int d = 0; d < 256; d++) begin
            for (int ai = 0; ai < 8; ai++) begin
                start_div(div_pick(ai), 8'(d));
                do_steps(16);
                div_expect(int'(div_pick(ai)), d, 16, ea, eq);
                if (d == 0) chk("R4 divide by zero", ea, eq);
                else        chk("R3 quotient/remainder", ea, eq);
            end
        end

        // R6: partial multiply after each step count.
        for (int k = 0; k <= 8; k++) begin
            start_mul(16'h00B7, 8'hD3);
            do_steps(k);
            chk("R6 partial product", 16'(32'hB7 * (32'hD3 & ((32'd1 << k) - 1))), 16'(8'hD3 >> k));
        end

        // R7: partial divide after each step count, including zero divisor.
        for (int k = 0; k <= 16; k++) begin
            start_div(16'hE5A1, 8'h13);
            do_steps(k);
            div_expect(32'hE5A1, 32'h13, k, ea, eq);
            chk("R7 partial divide", ea, eq);
            start_div(16'h4C2D, 8'h00);
            do_steps(k);
            div_expect(32'h4C2D, 0, k, ea, eq);
            chk("R7 partial divide by zero", ea, eq);
        end

        // R5: mid-operation idle cycles hold the partial result.
        start_mul(16'h0077, 8'h6B);
        do_steps(3);
        repeat (5) @(negedge clk);
        chk("R5 hold without step", 16'(32'h77 * (32'h6B & 32'h7)), 16'(8'h6B >> 3));
        do_steps(5);
        chk("R5 resume to product", 16'(32'h77 * 32'h6B), 16'h0);

        // R8: busy timing and steps beyond completion.
        start_div(16'h9999, 8'h07);
        do_steps(15);
        chk_busy("R8 busy before last step", 1'b1);
        do_steps(1);
        chk_busy("R8 busy after last step", 1'b0);
        do_steps(4);
        chk("R8 extra steps ignored", 16'(32'h9999 % 7), 16'(32'h9999 / 7));
        chk_busy("R8 still idle", 1'b0);

        // R9: abort in both directions.
        start_div(16'hFFFF, 8'h03);
        do_steps(5);
        start_mul(16'h00C9, 8'hE7);
        do_steps(8);
        chk("R9 multiply after aborted divide", 16'(32'hC9 * 32'hE7), 16'h0);
        start_mul(16'h00FF, 8'hFF);
        do_steps(4);
        start_div(16'h7F3E, 8'h2B);
        do_steps(16);
        chk("R9 divide after aborted multiply", 16'(32'h7F3E % 32'h2B), 16'(32'h7F3E / 32'h2B));

        // R10: both starts together select divide.
        @(negedge clk); a_in = 16'h5A5A; b_in = 8'h09; mul_start = 1'b1; div_start = 1'b1; step = 1'b0;
        do_steps(0);
        chk("R10 divide load wins", 16'h5A5A, 16'h0);
        do_steps(16);
        chk("R10 divide result", 16'(32'h5A5A % 9), 16'(32'h5A5A / 9));

        // R11: step coincident with start is not counted.
        @(negedge clk); a_in = 16'h00AB; b_in = 8'hCD; mul_start = 1'b1; div_start = 1'b0; step = 1'b1;
        do_steps(0);
        chk("R11 load only", 16'h0, 16'h00CD);
        chk_busy("R11 still busy", 1'b1);
        do_steps(7);
        chk_busy("R11 one step left", 1'b1);
        do_steps(1);
        chk("R11 product", 16'(32'hAB * 32'hCD), 16'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule